// File: doc/BRIEF.md
# Branch and Jump Target Resolver

This block works out where control goes next for two families of control-transfer instructions. The first family is the conditional branches that compare a register against zero, where the 5-bit `rt` field picks the condition. The second is the register jumps, with and without a link. The ISA has one delay slot after each branch. For every real branch or jump the block reports that a delay slot is pending, so the pipeline runs the next sequential instruction before it redirects. The block always produces a concrete next address. A taken branch resolves to its offset target, a not-taken branch resolves to the address just past the delay slot, and a non-transfer instruction resolves to the next sequential address.

The block also supplies the data for link-register writes. It checks register-jump targets for word alignment. It flags any branch or jump that arrives while the core is already executing a delay slot, because the pipeline cannot handle that nesting. Results are registered, so they appear one cycle after a request.

Top module: `bru_resolve`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it rises, every output is zero.
- R2: With `op_i` = 01, the `rt_i` codes 0, 1, 16 and 17 are branches that test `rs_val_i` as a signed number against zero. Codes 0 and 16 are taken when the value is below zero. Codes 1 and 17 are taken when the value is zero or above.
- R3: A taken branch resolves to `pc_i` + 4 + (the sign-extended `off_i` shifted left by 2), modulo 2^32.
- R4: A not-taken branch resolves to `pc_i` + 8, modulo 2^32.
- R5: Codes 16 and 17 write `pc_i` + 8 to register 31, whether or not the branch is taken.
- R6: With `op_i` = 10 (register jump) or 11 (register jump with link), the target is `rs_val_i`. If either of its two low bits is set, `addr_err_o` is 1 and `slot_pend_o` is 0. Otherwise `slot_pend_o` is 1 and `addr_err_o` is 0.
- R7: With `op_i` = 11, `pc_i` + 8 is written to the register indexed by `rd_i`, alignment notwithstanding. With `op_i` = 10 there is no link write.
- R8: A branch or jump presented with `in_slot_i` = 1 sets `nest_err_o`. Any other request leaves `nest_err_o` at 0.
- R9: With `op_i` = 01, the likely-branch codes 2, 3, 18 and 19, the trap codes 8 to 12 and 14, and every other `rt_i` code outside R2 have no effect. The same holds for `op_i` = 00. In these cases `slot_pend_o`, `link_we_o`, `addr_err_o` and `nest_err_o` are 0 and the target is `pc_i` + 4.
- R10: A request on `valid_i` gives `valid_o` and its results exactly one cycle later. In a cycle that follows no request, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 2 | 00 none, 01 compare-to-zero branch, 10 register jump, 11 register jump with link |
| pc_i | input | 32 | Address of the instruction |
| rs_val_i | input | 32 | Value of the source register |
| off_i | input | 16 | Branch offset in instructions |
| rt_i | input | 5 | Condition selector for branches |
| rd_i | input | 5 | Link destination for a register jump with link |
| in_slot_i | input | 1 | The instruction sits in a delay slot |
| valid_o | output | 1 | Result strobe |
| target_o | output | 32 | Resolved next address |
| slot_pend_o | output | 1 | Delay slot pending before the redirect |
| link_we_o | output | 1 | Link write enable |
| link_idx_o | output | 5 | Link destination register |
| link_data_o | output | 32 | Link value |
| addr_err_o | output | 1 | Misaligned register-jump target |
| nest_err_o | output | 1 | Branch or jump inside a delay slot |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, a 16-bit offset and 4-byte instructions. With these values, program counters near the top of the address space make both the forward-taken target and the `pc_i` + 8 path wrap past 2^32. The extreme offsets 0x7FFF and 0x8000 reach the largest forward and backward displacements. Random `rt_i` codes sweep every no-effect encoding. Random low bits on `rs_val_i` split register jumps between aligned and misaligned targets.

// File: rtl/bru_pkg.sv
package bru_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_REGIMM = 2'b01,
    OP_JR     = 2'b10,
    OP_JALR   = 2'b11
  } bru_op_e;

  // rt selector codes the pipeline decodes; values fixed by the ISA encoding
  localparam logic [4:0] RT_LTZ    = 5'd0;
  localparam logic [4:0] RT_GEZ    = 5'd1;
  localparam logic [4:0] RT_LTZ_AL = 5'd16;
  localparam logic [4:0] RT_GEZ_AL = 5'd17;

  typedef struct packed {
    logic xfer;       // real control transfer, opens a delay slot
    logic reg_jump;   // target comes from rs
    logic link_fix;   // link to the fixed return register
    logic link_rd;    // link to rd
    logic taken;      // branch condition result
  } bru_dec_t;
endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [1:0]       op_i,
  input  logic [REG_W-1:0] rt_i,
  input  logic             rs_neg_i,
  output bru_dec_t         dec_o
);
  bru_op_e op;
  assign op = bru_op_e'(op_i);

  always_comb begin
    dec_o = '0;
    unique case (op)
      OP_REGIMM: begin
        unique case (rt_i)
          RT_LTZ: begin
            dec_o.xfer  = 1'b1;
            dec_o.taken = rs_neg_i;
          end
          RT_GEZ: begin
            dec_o.xfer  = 1'b1;
            dec_o.taken = !rs_neg_i;
          end
          RT_LTZ_AL: begin
            dec_o.xfer     = 1'b1;
            dec_o.link_fix = 1'b1;
            dec_o.taken    = rs_neg_i;
          end
          RT_GEZ_AL: begin
            dec_o.xfer     = 1'b1;
            dec_o.link_fix = 1'b1;
            dec_o.taken    = !rs_neg_i;
          end
          default: dec_o = '0;  // likely, trap and reserved codes: no effect
        endcase
      end
      OP_JR: begin
        dec_o.xfer     = 1'b1;
        dec_o.reg_jump = 1'b1;
      end
      OP_JALR: begin
        dec_o.xfer     = 1'b1;
        dec_o.reg_jump = 1'b1;
        dec_o.link_rd  = 1'b1;
      end
      default: dec_o = '0;
    endcase
  end
endmodule

// File: rtl/bru_target.sv
module bru_target
  import bru_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 16,
  parameter int INSN_BYTES = 4
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] rs_val_i,
  input  logic [OFF_W-1:0]  off_i,
  input  bru_dec_t          dec_i,
  output logic [ADDR_W-1:0] target_o,
  output logic [ADDR_W-1:0] after_slot_o,
  output logic              misalign_o
);
  localparam int SH = $clog2(INSN_BYTES);
  localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(INSN_BYTES);
  localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * INSN_BYTES);

  logic [ADDR_W-1:0] off_sx, seq_pc, br_pc;

  assign off_sx       = {{(ADDR_W-OFF_W){off_i[OFF_W-1]}}, off_i};
  assign seq_pc       = pc_i + STEP1;
  assign br_pc        = seq_pc + (off_sx << SH);
  assign after_slot_o = pc_i + STEP2;

  generate
    if (SH > 0) begin : g_align
      assign misalign_o = |rs_val_i[SH-1:0];
    end else begin : g_noalign
      assign misalign_o = 1'b0;
    end
  endgenerate

  always_comb begin
    if (!dec_i.xfer)          target_o = seq_pc;
    else if (dec_i.reg_jump)  target_o = rs_val_i;
    else if (dec_i.taken)     target_o = br_pc;
    else                      target_o = after_slot_o;
  end
endmodule

// File: rtl/bru_resolve.sv
module bru_resolve
  import bru_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 16,
  parameter int REG_W      = 5,
  parameter int INSN_BYTES = 4,
  parameter int LINK_REG   = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] rs_val_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [REG_W-1:0]  rt_i,
  input  logic [REG_W-1:0]  rd_i,
  input  logic              in_slot_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] target_o,
  output logic              slot_pend_o,
  output logic              link_we_o,
  output logic [REG_W-1:0]  link_idx_o,
  output logic [ADDR_W-1:0] link_data_o,
  output logic              addr_err_o,
  output logic              nest_err_o
);
  localparam logic [REG_W-1:0]  LINK_IDX = REG_W'(LINK_REG);
  localparam logic [ADDR_W-1:0] STEP2    = ADDR_W'(2 * INSN_BYTES);

  bru_dec_t          dec;
  logic [ADDR_W-1:0] tgt_d, after_slot;
  logic              misalign;

  bru_decode #(.REG_W(REG_W)) u_dec (
    .op_i     (op_i),
    .rt_i     (rt_i),
    .rs_neg_i (rs_val_i[ADDR_W-1]),
    .dec_o    (dec)
  );

  bru_target #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .INSN_BYTES(INSN_BYTES)) u_tgt (
    .pc_i         (pc_i),
    .rs_val_i     (rs_val_i),
    .off_i        (off_i),
    .dec_i        (dec),
    .target_o     (tgt_d),
    .after_slot_o (after_slot),
    .misalign_o   (misalign)
  );

  logic addr_err_d;
  assign addr_err_d = dec.reg_jump && misalign;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      target_o    <= '0;
      slot_pend_o <= 1'b0;
      link_we_o   <= 1'b0;
      link_idx_o  <= '0;
      link_data_o <= '0;
      addr_err_o  <= 1'b0;
      nest_err_o  <= 1'b0;
    end else if (valid_i) begin
      valid_o     <= 1'b1;
      target_o    <= tgt_d;
      slot_pend_o <= dec.xfer && !addr_err_d;
      link_we_o   <= dec.link_fix || dec.link_rd;
      link_idx_o  <= dec.link_rd ? rd_i : (dec.link_fix ? LINK_IDX : '0);
      link_data_o <= (dec.link_fix || dec.link_rd) ? after_slot : '0;
      addr_err_o  <= addr_err_d;
      nest_err_o  <= dec.xfer && in_slot_i;
    end else begin
      valid_o     <= 1'b0;
      target_o    <= '0;
      slot_pend_o <= 1'b0;
      link_we_o   <= 1'b0;
      link_idx_o  <= '0;
      link_data_o <= '0;
      addr_err_o  <= 1'b0;
      nest_err_o  <= 1'b0;
    end
  end

  AST_NOT_TAKEN_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b01 && rt_i == RT_GEZ && rs_val_i[ADDR_W-1])
      |=> (target_o == $past(pc_i) + STEP2 && slot_pend_o)); // R4

  AST_LINK_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b01 && (rt_i == RT_LTZ_AL || rt_i == RT_GEZ_AL))
      |=> (link_we_o && link_idx_o == LINK_IDX && link_data_o == $past(pc_i) + STEP2)); // R5

  AST_MISALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[1] && rs_val_i[1:0] != 2'b00)
      |=> (addr_err_o && !slot_pend_o)); // R6

  AST_NEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && in_slot_i && op_i[1]) |=> nest_err_o); // R8

  AST_LIKELY_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b01 && (rt_i == 5'd2 || rt_i == 5'd3 || rt_i == 5'd18 || rt_i == 5'd19))
      |=> (!slot_pend_o && !link_we_o && !nest_err_o && !addr_err_o)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !slot_pend_o && !link_we_o && !addr_err_o && !nest_err_o)); // R10
endmodule

// File: tb/bru_resolve_test.sv
module bru_resolve_test;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [31:0] pc_i = '0, rs_val_i = '0;
  logic [15:0] off_i = '0;
  logic [4:0]  rt_i = '0, rd_i = '0;
  logic        in_slot_i = 1'b0;
  logic        valid_o, slot_pend_o, link_we_o, addr_err_o, nest_err_o;
  logic [31:0] target_o, link_data_o;
  logic [4:0]  link_idx_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  bru_resolve uut (
    .clk_i, .rst_ni, .valid_i, .op_i, .pc_i, .rs_val_i, .off_i, .rt_i, .rd_i,
    .in_slot_i, .valid_o, .target_o, .slot_pend_o, .link_we_o, .link_idx_o,
    .link_data_o, .addr_err_o, .nest_err_o
  );

  typedef struct {
    logic [31:0] tgt;
    logic        pend;
    logic        we;
    logic [4:0]  idx;
    logic [31:0] ldata;
    logic        aerr;
    logic        nerr;
    string       tgt_req;
  } exp_t;

  function automatic exp_t model(logic [1:0] op, logic [31:0] pc, logic [31:0] rs,
                                 logic [15:0] off, logic [4:0] rt, logic [4:0] rd,
                                 logic slot);
    exp_t e;
    logic br, tk;
    e.tgt = pc + 32'd4; e.pend = 0; e.we = 0; e.idx = 0; e.ldata = 0;
    e.aerr = 0; e.nerr = 0; e.tgt_req = "R9";
    br = 0; tk = 0;
    if (op == 2'b01) begin
      if (rt == 5'd0 || rt == 5'd16) begin br = 1; tk = ($signed(rs) < 0); end
      if (rt == 5'd1 || rt == 5'd17) begin br = 1; tk = ($signed(rs) >= 0); end
      if (br) begin
        e.pend = 1; e.nerr = slot;
        if (tk) begin
          e.tgt = pc + 32'd4 + ({{16{off[15]}}, off} * 32'd4); e.tgt_req = "R3";
        end else begin
          e.tgt = pc + 32'd8; e.tgt_req = "R4";
        end
        if (rt[4]) begin e.we = 1; e.idx = 5'd31; e.ldata = pc + 32'd8; end
      end
    end else if (op[1]) begin
      e.tgt = rs; e.tgt_req = "R6"; e.nerr = slot;
      e.aerr = (rs[1:0] != 0); e.pend = !e.aerr;
      if (op[0]) begin e.we = 1; e.idx = rd; e.ldata = pc + 32'd8; end
    end
    return e;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] op, logic [31:0] pc, logic [31:0] rs,
                       logic [15:0] off, logic [4:0] rt, logic [4:0] rd, logic slot);
    exp_t e;
    string lreq;
    e = model(op, pc, rs, off, rt, rd, slot);
    lreq = (op == 2'b01) ? "R5" : "R7";
    valid_i = 1; op_i = op; pc_i = pc; rs_val_i = rs; off_i = off;
    rt_i = rt; rd_i = rd; in_slot_i = slot;
    @(negedge clk_i);
    check("R10", "valid", {31'd0, valid_o}, 32'd1);
    check(e.tgt_req, "target", target_o, e.tgt);
    check((op == 2'b01) ? "R2" : "R6", "slot_pend", {31'd0, slot_pend_o}, {31'd0, e.pend});
    check(lreq, "link_we", {31'd0, link_we_o}, {31'd0, e.we});
    if (e.we) begin
      check(lreq, "link_idx", {27'd0, link_idx_o}, {27'd0, e.idx});
      check(lreq, "link_data", link_data_o, e.ldata);
    end
    check("R6", "addr_err", {31'd0, addr_err_o}, {31'd0, e.aerr});
    check("R8", "nest_err", {31'd0, nest_err_o}, {31'd0, e.nerr});
  endtask

  task automatic idle_check();
    valid_i = 0; op_i = 2'b11; rs_val_i = 32'h3; in_slot_i = 1;
    @(negedge clk_i);
    check("R10", "idle outputs",
          {valid_o, slot_pend_o, link_we_o, addr_err_o, nest_err_o, link_idx_o, 22'd0} | target_o | link_data_o,
          32'd0);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk_i);
    check("R1", "reset outputs",
          {valid_o, slot_pend_o, link_we_o, addr_err_o, nest_err_o, link_idx_o, 22'd0} | target_o | link_data_o,
          32'd0);
    rst_ni = 1;
    @(negedge clk_i);
    check("R1", "first cycle after reset", {31'd0, valid_o} | target_o, 32'd0);

    // directed corner cases
    issue(2'b01, 32'h0000_1000, 32'h8000_0000, 16'h0010, 5'd0,  5'd0, 0); // R2 taken on negative
    issue(2'b01, 32'h0000_1000, 32'h0000_0000, 16'h0010, 5'd0,  5'd0, 0); // R2 zero not below
    issue(2'b01, 32'h0000_1000, 32'h0000_0000, 16'hFFFF, 5'd1,  5'd0, 0); // R3 backward
    issue(2'b01, 32'hFFFF_FFF0, 32'h0000_0005, 16'h7FFF, 5'd1,  5'd0, 0); // R3 wrap
    issue(2'b01, 32'h0000_0040, 32'h0000_0005, 16'h8000, 5'd17, 5'd0, 0); // R3 min offset, R5
    issue(2'b01, 32'hFFFF_FFFC, 32'hFFFF_FFFF, 16'h0003, 5'd17, 5'd0, 0); // R4 wrap, R5 not taken
    issue(2'b01, 32'h0000_2000, 32'h0000_0001, 16'h0003, 5'd16, 5'd0, 1); // R5 R8
    issue(2'b10, 32'h0000_3000, 32'h0040_0002, 16'h0000, 5'd0,  5'd0, 0); // R6 misaligned
    issue(2'b11, 32'h0000_3000, 32'h0040_0001, 16'h0000, 5'd0,  5'd9, 0); // R6 R7
    issue(2'b11, 32'hFFFF_FFF8, 32'h0040_0100, 16'h0000, 5'd0,  5'd31, 1); // R7 R8
    issue(2'b10, 32'h0000_3000, 32'h0040_0100, 16'h0000, 5'd0,  5'd9, 1); // R8
    issue(2'b01, 32'h0000_4000, 32'h8000_0000, 16'h0004, 5'd2,  5'd0, 1); // R9 likely
    issue(2'b01, 32'h0000_4000, 32'h0000_0000, 16'h0004, 5'd19, 5'd0, 0); // R9 likely link
    issue(2'b01, 32'h0000_4000, 32'h0000_0000, 16'h0004, 5'd12, 5'd0, 1); // R9 trap code
    issue(2'b00, 32'hFFFF_FFFC, 32'h0000_0003, 16'h0004, 5'd0,  5'd3, 1); // R9 none, wrap
    idle_check();                                                         // R10

    // constrained random
    for (int i = 0; i < 2000; i++) begin
      logic [1:0]  op;
      logic [31:0] pc, rs;
      logic [4:0]  rt;
      op = 2'($urandom_range(0, 3));
      pc = {$urandom()} & 32'hFFFF_FFFC;
      if ($urandom_range(0, 7) == 0) pc = 32'hFFFF_FFF0 | (pc & 32'hC);
      rs = $urandom();
      if ($urandom_range(0, 1) == 0) rs[1:0] = 2'b00;
      rt = ($urandom_range(0, 1) == 0) ? (($urandom_range(0, 1) == 0) ? 5'd0 : 5'd16) | 5'($urandom_range(0, 1))
                                      : 5'($urandom_range(0, 31));
      issue(op, pc, rs, 16'($urandom()), rt, 5'($urandom()), 1'($urandom()));
      if ($urandom_range(0, 15) == 0) idle_check();
    end

    valid_i = 0;
    @(negedge clk_i);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule